// File: doc/BRIEF.md
# Sixteen-Bit Accumulator Processor Core

This block is a small multi-cycle processor built around one 16-bit accumulator. Each instruction word holds a 4-bit opcode in its top nibble and a 12-bit operand below it. The operand is a memory address, a jump target, an immediate value or a shift count, depending on the opcode. A fixed sequencer of eight phases takes every instruction from fetch to accumulator write-back. The core therefore spends exactly eight clocks on each instruction, with no stalls and no overlap.

The core drives a 12-bit address, a read strobe and a write strobe on a 16-bit memory bus. Read data must be valid in the same cycle as the read strobe, so the memory answers combinationally. The upper sixteenth of the address space is an I/O window and never reaches memory. A store to the first address of that window loads a 16-bit output port. Calls go one level deep through a single link register. The program counter, instruction register, accumulator, link register, zero flag and halt state are brought out as ports for display.

Top module: `acc16_core`

## Requirements
- R1: A synchronous active-low reset clears the PC, the instruction register, the accumulator, the link register, the output port and the halt state, and sets the zero flag. After reset, fetching starts at address 0x000.
- R2: Bits 15:12 of an instruction select the opcode and bits 11:0 hold the operand. The encodings are NOP 0000, LDA 0001, STA 0010, LDI 0011, JMP 0100, JPZ 0101, JL 0110, RET 0111, ADD 1000, SUB 1001, AND 1010, XOR 1011, SHL 1100, SHR 1101 and HALT 1111. The code 1110 acts as NOP. Every instruction takes eight clocks: the fetch read is in phase 1 at the PC, and any data access is in phase 5 at the operand address.
- R3: LDA loads the memory word at the operand address. LDI loads the operand sign-extended from bit 11. STA drives the accumulator on the write data with the write strobe.
- R4: ADD, AND and XOR combine the accumulator with the memory word at the operand address. SUB computes accumulator minus memory word, modulo 2^16. The result replaces the accumulator.
- R5: SHL and SHR shift the accumulator by the operand value itself. SHR is logical and fills with zeros. Any count of 16 or more gives zero.
- R6: The zero flag equals (accumulator == 0) after every accumulator load. JMP sets the PC to the operand. JPZ does the same only when the zero flag is set, and otherwise moves to PC+1.
- R7: JL stores PC+1 in the link register and jumps to the operand. RET loads the PC from the link register.
- R8: Operand addresses 0xF00 to 0xFFF form the I/O window. In that window no memory strobe is raised and reads return zero. A store to 0xF00 pulses out_we and loads out_port with the accumulator. Stores to other window addresses have no effect.
- R9: After HALT, the core raises halted and keeps it. From then on it drives no read, write or port strobe, and the PC and accumulator stay frozen until reset.
- R10: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Bus address |
| mem_rd | output | 1 | Read strobe, data sampled at the end of the cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, valid while mem_rd is high |
| out_port | output | 16 | Memory-mapped output register |
| out_we | output | 1 | High in the cycle that loads out_port |
| pc_q | output | 12 | Program counter |
| ir_q | output | 16 | Instruction register |
| acc_q | output | 16 | Accumulator |
| link_q | output | 12 | Return-address register |
| zero_q | output | 1 | Zero flag |
| halted | output | 1 | Core stopped by HALT |

## Verification
A wrong value in the PC, the link register or the zero flag sends fetches to the wrong address. This shows up at the output port as a missing, extra or out-of-order value within one or two instructions, which is 8 to 16 clocks. A corrupted accumulator or ALU result appears in the next port store. A sequencer that drops or adds a phase moves the cycle at which halted rises. A store routed to the wrong place shows up as a memory strobe inside the I/O window or as a port pulse at an address other than 0xF00.

// File: rtl/acc16_pkg.sv
// Package: shared sizes and the opcode type of the accumulator core.
// Assumes a 16-bit word with a 4-bit opcode on top of a 12-bit operand.
package acc16_pkg;
    localparam int WORD_W  = 16;
    localparam int OPND_W  = 12;
    localparam int OPC_W   = WORD_W - OPND_W;
    localparam int NPHASE  = 8;
    localparam int PH_W    = $clog2(NPHASE);

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 4'b0000,
        OP_LDA  = 4'b0001,
        OP_STA  = 4'b0010,
        OP_LDI  = 4'b0011,
        OP_JMP  = 4'b0100,
        OP_JPZ  = 4'b0101,
        OP_JL   = 4'b0110,
        OP_RET  = 4'b0111,
        OP_ADD  = 4'b1000,
        OP_SUB  = 4'b1001,
        OP_AND  = 4'b1010,
        OP_XOR  = 4'b1011,
        OP_SHL  = 4'b1100,
        OP_SHR  = 4'b1101,
        OP_RSV  = 4'b1110,
        OP_HALT = 4'b1111
    } opcode_t;

    // Phase numbers used by the datapath
    localparam logic [PH_W-1:0] PH_FETCH = PH_W'(1);
    localparam logic [PH_W-1:0] PH_DEC   = PH_W'(2);
    localparam logic [PH_W-1:0] PH_PC    = PH_W'(3);
    localparam logic [PH_W-1:0] PH_DATA  = PH_W'(5);
    localparam logic [PH_W-1:0] PH_ALU   = PH_W'(6);
    localparam logic [PH_W-1:0] PH_WB    = PH_W'(7);
endpackage

// File: rtl/acc16_seq.sv
// Phase sequencer: steps a phase counter through NPHASE states per
// instruction and freezes it once a halt request is seen in decode.
// Assumes halt_req is only meaningful while the phase is PH_DEC.
module acc16_seq
    import acc16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_req,
    output logic [PH_W-1:0] phase,
    output logic            halted
);
    localparam logic [PH_W-1:0] LAST = PH_W'(NPHASE - 1);

    // Advance the phase and latch the halt state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            halted <= 1'b0;
        end else if (!halted) begin
            if (phase == PH_DEC && halt_req)
                halted <= 1'b1;
            else
                phase <= (phase == LAST) ? '0 : phase + PH_W'(1);
        end
    end
endmodule

// File: rtl/acc16_alu.sv
// Combinational ALU: produces the next accumulator value for every
// accumulator-writing opcode. Assumes mem_val is already zero for
// reads in the I/O window.
module acc16_alu
    import acc16_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int OW = OPND_W
) (
    input  opcode_t         op,
    input  logic [W-1:0]    acc,
    input  logic [W-1:0]    mem_val,
    input  logic [OW-1:0]   opnd,
    output logic [W-1:0]    result
);
    localparam int SH_W = $clog2(W);

    logic          big_shift;
    logic [W-1:0]  imm_ext;

    // Sign-extend the immediate and flag out-of-range shift counts
    always_comb begin
        imm_ext   = {{(W-OW){opnd[OW-1]}}, opnd};
        big_shift = (opnd >= OW'(W));
    end

    // Select the operation result
    always_comb begin
        unique case (op)
            OP_LDA:  result = mem_val;
            OP_LDI:  result = imm_ext;
            OP_ADD:  result = acc + mem_val;
            OP_SUB:  result = acc - mem_val;
            OP_AND:  result = acc & mem_val;
            OP_XOR:  result = acc ^ mem_val;
            OP_SHL:  result = big_shift ? '0 : acc << opnd[SH_W-1:0];
            OP_SHR:  result = big_shift ? '0 : acc >> opnd[SH_W-1:0];
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc16_core.sv
// Accumulator processor top: registers, decode and bus control.
// Assumes a memory that returns read data in the cycle of mem_rd.
// Operand addresses at or above IO_BASE go to the I/O window.
module acc16_core
    import acc16_pkg::*;
#(
    parameter int          W       = WORD_W,
    parameter int          AW      = OPND_W,
    parameter logic [11:0] IO_BASE = 12'hF00,
    parameter logic [11:0] IO_PORT = 12'hF00
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic [W-1:0]  out_port,
    output logic          out_we,
    output logic [AW-1:0] pc_q,
    output logic [W-1:0]  ir_q,
    output logic [W-1:0]  acc_q,
    output logic [AW-1:0] link_q,
    output logic          zero_q,
    output logic          halted
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [PH_W-1:0] phase;
    opcode_t         op;
    logic [AW-1:0]   opnd;
    logic            in_io, reads_mem, writes_acc, run;
    logic [W-1:0]    dbuf, alu_q, alu_res;

    acc16_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (op == OP_HALT),
        .phase    (phase),
        .halted   (halted)
    );

    acc16_alu #(.W(W), .OW(AW)) u_alu (
        .op      (op),
        .acc     (acc_q),
        .mem_val (dbuf),
        .opnd    (opnd),
        .result  (alu_res)
    );

    // Decode the held instruction into control terms
    always_comb begin
        op         = opcode_t'(ir_q[W-1 -: OPC_W]);
        opnd       = ir_q[AW-1:0];
        in_io      = (opnd >= AW'(IO_BASE));
        run        = !halted;
        reads_mem  = op inside {OP_LDA, OP_ADD, OP_SUB, OP_AND, OP_XOR};
        writes_acc = op inside {OP_LDA, OP_LDI, OP_ADD, OP_SUB,
                                OP_AND, OP_XOR, OP_SHL, OP_SHR};
    end

    // Drive the bus: PC early in the instruction, operand from phase 4
    always_comb begin
        mem_addr  = (phase > PH_PC) ? opnd : pc_q;
        mem_wdata = acc_q;
        mem_rd    = run && ((phase == PH_FETCH) ||
                            (phase == PH_DATA && reads_mem && !in_io));
        mem_wr    = run && phase == PH_DATA && op == OP_STA && !in_io;
        out_we    = run && phase == PH_DATA && op == OP_STA &&
                    opnd == AW'(IO_PORT);
    end

    // Instruction fetch
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_q <= '0;
        else if (run && phase == PH_FETCH)
            ir_q <= mem_rdata;
    end

    // PC and link register update in the PC phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            link_q <= '0;
        end else if (run && phase == PH_PC) begin
            unique case (op)
                OP_JMP:  pc_q <= opnd;
                OP_JPZ:  pc_q <= zero_q ? opnd : pc_q + ONE;
                OP_JL: begin
                    link_q <= pc_q + ONE;
                    pc_q   <= opnd;
                end
                OP_RET:  pc_q <= link_q;
                default: pc_q <= pc_q + ONE;
            endcase
        end
    end

    // Data capture, ALU result and accumulator write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbuf   <= '0;
            alu_q  <= '0;
            acc_q  <= '0;
            zero_q <= 1'b1;
        end else if (run) begin
            if (phase == PH_DATA)
                dbuf <= in_io ? '0 : mem_rdata;
            if (phase == PH_ALU)
                alu_q <= alu_res;
            if (phase == PH_WB && writes_acc) begin
                acc_q  <= alu_q;
                zero_q <= (alu_q == '0);
            end
        end
    end

    // Memory-mapped output port
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_port <= '0;
        else if (out_we)
            out_port <= acc_q;
    end
endmodule

// File: rtl/acc16_chk.sv
// Checker: temporal properties of the accumulator core, bound to
// every instance. Assumes only port-level visibility.
module acc16_chk #(
    parameter int W  = 16,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          out_we,
    input logic [W-1:0]  out_port,
    input logic [AW-1:0] pc_q,
    input logic [W-1:0]  acc_q,
    input logic          zero_q,
    input logic          halted
);
    // R1: reset clears the state
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && acc_q == '0 && !halted && out_port == '0));

    // R10: no read and write together
    a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8: no memory write inside the I/O window
    a_r8_no_io_memwr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr < AW'(12'hF00));

    // R8: port pulse only at the port address
    a_r8_port_addr: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> mem_addr == AW'(12'hF00));

    // R8: port takes the accumulator
    a_r8_port_load: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> out_port == $past(acc_q));

    // R9: halt is sticky and quiet
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr && !out_we));
    a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted && $past(halted) |-> ($stable(pc_q) && $stable(acc_q)));

    // R6: zero flag tracks the accumulator
    a_r6_zero_track: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q == (acc_q == '0));
endmodule

bind acc16_core acc16_chk #(.W(W), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .out_we   (out_we),
    .out_port (out_port),
    .pc_q     (pc_q),
    .acc_q    (acc_q),
    .zero_q   (zero_q),
    .halted   (halted)
);

// File: tb/sim_acc16_core.sv
// Bench: a program exercising every opcode. A driver task queues the
// expected output-port values and a monitor compares each port load.
module sim_acc16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr, out_we, zero_q, halted;
    logic [15:0] mem_wdata, mem_rdata, out_port, ir_q, acc_q;
    logic [11:0] pc_q, link_q;

    logic [15:0] mem [0:255];
    logic [15:0] exp_q [$];
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    logic        pend = 1'b0;
    logic        live = 1'b0;

    always #10 clk = ~clk;

    acc16_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_port(out_port), .out_we(out_we), .pc_q(pc_q), .ir_q(ir_q),
        .acc_q(acc_q), .link_q(link_q), .zero_q(zero_q), .halted(halted)
    );

    // Memory model with combinational read
    assign mem_rdata = mem_rd ? mem[mem_addr[7:0]] : 16'h0000;
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_exp(input logic [15:0] v);
        exp_q.push_back(v);
    endtask

    // Monitor: compare each port load with the queue head
    always @(negedge clk) begin
        if (live && pend) begin
            if (exp_q.size() == 0) check("R8 unexpected port load", {16'h0, out_port}, 32'hDEAD);
            else check("R3/R4/R5/R6/R7 port value", {16'h0, out_port}, {16'h0, exp_q.pop_front()});
        end
        pend = out_we;
        if (live && mem_wr && mem_addr >= 12'hF00)
            check("R8 memory write in I/O window", 1, 0);
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h00] = 16'h3005; mem[8'h01] = 16'h2F00;  // LDI 5, out
        mem[8'h02] = 16'h3FFD; mem[8'h03] = 16'h2F00;  // LDI -3, out
        mem[8'h04] = 16'h1080; mem[8'h05] = 16'h2F00;  // LDA
        mem[8'h06] = 16'h8081; mem[8'h07] = 16'h2F00;  // ADD
        mem[8'h08] = 16'hB083; mem[8'h09] = 16'h2F00;  // XOR
        mem[8'h0A] = 16'hA084; mem[8'h0B] = 16'h2F00;  // AND
        mem[8'h0C] = 16'hC004; mem[8'h0D] = 16'h2F00;  // SHL 4
        mem[8'h0E] = 16'hD008; mem[8'h0F] = 16'h2F00;  // SHR 8
        mem[8'h10] = 16'hD010; mem[8'h11] = 16'h5014;  // SHR 16, JPZ taken
        mem[8'h12] = 16'h3111; mem[8'h13] = 16'h2F00;  // skipped
        mem[8'h14] = 16'h3001; mem[8'h15] = 16'h5018;  // JPZ not taken
        mem[8'h16] = 16'h3222; mem[8'h17] = 16'h2F00;
        mem[8'h18] = 16'h6030; mem[8'h19] = 16'h2F00;  // JL, out after RET
        mem[8'h1A] = 16'h2090; mem[8'h1B] = 16'h4020;  // STA mem, JMP
        mem[8'h1C] = 16'h3999;
        mem[8'h20] = 16'h9085; mem[8'h21] = 16'h2F00;  // SUB, out
        mem[8'h22] = 16'h0000; mem[8'h23] = 16'h2F01;  // NOP, I/O store ignored
        mem[8'h24] = 16'hF000;                         // HALT
        mem[8'h30] = 16'h3777; mem[8'h31] = 16'h7000;  // LDI, RET
        mem[8'h80] = 16'h1234; mem[8'h81] = 16'h0011; mem[8'h83] = 16'h00FF;
        mem[8'h84] = 16'h0F0F; mem[8'h85] = 16'h0778;

        push_exp(16'h0005); push_exp(16'hFFFD);  // R3 LDI sign-extension
        push_exp(16'h1234); push_exp(16'h1245);  // R3 LDA, R4 ADD
        push_exp(16'h12BA); push_exp(16'h020A);  // R4 XOR, AND
        push_exp(16'h20A0); push_exp(16'h0020);  // R5 shifts
        push_exp(16'h0222); push_exp(16'h0777);  // R6 JPZ, R7 JL/RET
        push_exp(16'hFFFF);                      // R4 SUB wraps

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pc after reset", {20'h0, pc_q}, 32'h0);
        check("R1 acc after reset", {16'h0, acc_q}, 32'h0);
        check("R1 strobes in reset", {29'h0, mem_rd, mem_wr, out_we}, 32'h0);
        check("R1 zero flag set", {31'h0, zero_q}, 32'h1);
        rst_n = 1'b1;
        live  = 1'b1;

        while (!halted && cyc < 5000) @(negedge clk);
        if (!halted) check("watchdog: halt never reached", 0, 1);
        else begin
            check("R2 eight clocks per instruction", cyc, 259);
            check("R9 pc at halt", {20'h0, pc_q}, 32'h024);
            check("R7 link register", {20'h0, link_q}, 32'h019);
            check("R3 store to memory", {16'h0, mem[8'h90]}, 32'h0777);
            check("R6 zero flag clear", {31'h0, zero_q}, 32'h0);
            check("R8 ignored I/O store kept port", {16'h0, out_port}, 32'hFFFF);
            repeat (40) begin
                @(negedge clk);
                if (mem_rd || mem_wr || out_we) check("R9 strobe after halt", 1, 0);
            end
            check("R9 pc frozen", {20'h0, pc_q}, 32'h024);
            check("R9 acc frozen", {16'h0, acc_q}, 32'hFFFF);
        end
        check("R8 all port loads seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule